// File: doc/BRIEF.md
# Shadowed Control Register Bank

This block holds a small bank of byte-wide control registers behind a serial-bus front end. Four of the registers, the shadowed ones at addresses 1 to 4, keep two copies of every bit. The working copy drives the device function through parallel output ports. The persistent copy survives a power-up reset and is modelled as plain storage with a commit pulse. A mode bit in register 0 selects one of two write behaviours for the shadowed registers. In write-through mode a write updates both copies. In working-only mode a write changes only the working copy, and the change is lost at the next power-up.

Register 5 is a general control byte. Register 6 holds the write-enable latch. In working-only mode, an accepted write to register 0 or register 5 reloads every working copy from its persistent copy. Writes are gated by the write-enable latch and by an active-low write-protect input. Reads of the shadowed registers always return the persistent copy.

Top module: `shadow_ctrl_bank`

## Requirements
- R1: While rst_ni is low, vol_o is zero. On the first rising clock edge after rst_ni goes high, each working copy is loaded from its persistent copy. Persistent contents are kept across rst_ni, and start from parameter NV_INIT, where register k sits at bits [(k-1)*8 +: 8].
- R2: When bit 7 of register 0 is 1, an accepted write to register k (1..4) sets both copies to the written byte. nv_commit_o bit k-1 is then high for exactly the one cycle after the write edge.
- R3: When bit 7 of register 0 is 0, an accepted write to register k (1..4) changes only the working copy. It raises no commit pulse. The new value appears on vol_o slice k-1 after the write edge.
- R4: An accepted write to register 0 or register 5 reloads all four working copies from their persistent copies when bit 7 of register 0 was 0 before that write. When that bit was 1, no reload happens.
- R5: A read returns its byte on rdata_o in the cycle after rd_i. For registers 1..4 that byte is the persistent copy, whatever the mode.
- R6: A write to register 6 sets the write-enable latch from wdata_i bit 0. This write takes effect regardless of wp_ni and of the latch itself. Register 6 reads back as the latch in bit 0 and zeros in the other bits. The latch is 0 after reset.
- R7: A write to registers 0..5 is accepted only when the latch is 1 and wp_ni is 1. Otherwise both copies, registers 0 and 5, and nv_commit_o stay unchanged, and no reload happens.
- R8: Registers 0 and 5 read back the last accepted byte (0 after reset). Address 7 reads as 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-up reset |
| wp_ni | input | 1 | Write protect, active low |
| wr_i | input | 1 | Byte write request |
| rd_i | input | 1 | Byte read request |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after rd_i |
| vol_o | output | 32 | Working copies of registers 1..4, register k at [(k-1)*8 +: 8] |
| nv_commit_o | output | 4 | One-cycle pulse per persistent-copy update |

## Verification
The bench targets the reload trigger. A write to register 0 that flips the mode must decide the reload on the old mode bit. A design that used the new value would skip the reload, or reload when it should not. Read-back of a shadowed register after a working-only write catches a read mux that returns the working copy. A power cycle after working-only writes checks that the persistent copy survives reset while the working edits are discarded. Writes under write-protect or without the latch, including the latch write that must still pass, catch gating that either blocks too much or leaks a reload or commit pulse.

// File: rtl/shadow_ctrl_pkg.sv
package shadow_ctrl_pkg;
  localparam int unsigned MODE_BIT = 7;
  localparam int unsigned WEL_BIT  = 0;
endpackage

// File: rtl/shadow_ctrl_decode.sv
module shadow_ctrl_decode #(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_SH   = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [N_SH-1:0]   sh_we_o,
  output logic              recall_o,
  output logic              wt_mode_o,
  output logic [DW-1:0]     mode_reg_o,
  output logic [DW-1:0]     aux_reg_o,
  output logic              wel_o
);
  import shadow_ctrl_pkg::*;

  localparam logic [ADDR_W-1:0] A_MODE = '0;
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(N_SH + 1);
  localparam logic [ADDR_W-1:0] A_WEL  = ADDR_W'(N_SH + 2);

  logic [DW-1:0] mode_q, aux_q;
  logic          wel_q, boot_q;
  logic          gate_ok, hit_mode, hit_aux;

  assign gate_ok  = wr_i & wel_q & wp_ni;
  assign hit_mode = gate_ok & (addr_i == A_MODE);
  assign hit_aux  = gate_ok & (addr_i == A_AUX);

  // reload decision uses the mode in force before this write
  assign recall_o   = boot_q | ((hit_mode | hit_aux) & ~mode_q[MODE_BIT]);
  assign wt_mode_o  = mode_q[MODE_BIT];
  assign mode_reg_o = mode_q;
  assign aux_reg_o  = aux_q;
  assign wel_o      = wel_q;

  for (genvar k = 0; k < N_SH; k++) begin : g_we
    assign sh_we_o[k] = gate_ok & (addr_i == ADDR_W'(k + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      aux_q  <= '0;
      wel_q  <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      if (hit_mode) mode_q <= wdata_i;
      if (hit_aux)  aux_q  <= wdata_i;
      if (wr_i && addr_i == A_WEL) wel_q <= wdata_i[WEL_BIT];
    end
  end

  a_r6_wel_always_writable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_WEL) |=> (wel_q == $past(wdata_i[WEL_BIT])));
  a_r7_one_shadow_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sh_we_o));
  a_r7_blocked_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni || !wel_q) |=> ($stable(mode_q) && $stable(aux_q)));
endmodule

// File: rtl/shadow_ctrl_cell.sv
module shadow_ctrl_cell #(
  parameter int unsigned   DW   = 8,
  parameter logic [DW-1:0] INIT = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          wt_i,
  input  logic          recall_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] vol_o,
  output logic [DW-1:0] nv_o,
  output logic          commit_o
);
  logic [DW-1:0] nv_q = INIT;
  logic [DW-1:0] vol_q;
  logic          commit_q;

  // persistent copy: no reset, survives power-up
  always_ff @(posedge clk_i) begin
    if (we_i && wt_i) nv_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vol_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= we_i & wt_i;
      if (recall_i)  vol_q <= nv_q;
      else if (we_i) vol_q <= wdata_i;
    end
  end

  assign vol_o    = vol_q;
  assign nv_o     = nv_q;
  assign commit_o = commit_q;

  a_r1_recall_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_i |=> (vol_q == $past(nv_q)));
  a_r2_commit_on_wt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wt_i) |=> (commit_o && nv_q == $past(wdata_i)));
  a_r3_vol_only_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wt_i) |=> (!commit_o && $stable(nv_q) && vol_q == $past(wdata_i)));
  a_r7_idle_nv_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(nv_q));
endmodule

// File: rtl/shadow_ctrl_rdmux.sv
module shadow_ctrl_rdmux #(
  parameter int unsigned DW     = 8,
  parameter int unsigned N_SH   = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [N_SH*DW-1:0] nv_i,
  input  logic [DW-1:0]      mode_reg_i,
  input  logic [DW-1:0]      aux_reg_i,
  input  logic               wel_i,
  output logic [DW-1:0]      rdata_o
);
  import shadow_ctrl_pkg::*;

  logic [DW-1:0] sel;
  logic [DW-1:0] rdata_q;

  always_comb begin
    sel = '0;
    if (addr_i == '0) sel = mode_reg_i;
    for (int k = 0; k < int'(N_SH); k++) begin
      if (addr_i == ADDR_W'(k + 1)) sel = nv_i[k*DW +: DW];
    end
    if (addr_i == ADDR_W'(N_SH + 1)) sel = aux_reg_i;
    if (addr_i == ADDR_W'(N_SH + 2)) begin
      sel = '0;
      sel[WEL_BIT] = wel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= sel;
  end

  assign rdata_o = rdata_q;

  a_r5_read_registered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/shadow_ctrl_bank.sv
module shadow_ctrl_bank #(
  parameter int unsigned           DW      = 8,
  parameter int unsigned           N_SH    = 4,
  parameter logic [N_SH*DW-1:0]    NV_INIT = 32'hC33C_A55A,
  localparam int unsigned          ADDR_W  = $clog2(N_SH + 3)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wp_ni,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [N_SH*DW-1:0] vol_o,
  output logic [N_SH-1:0]    nv_commit_o
);
  logic [N_SH-1:0]    sh_we;
  logic               recall, wt_mode, wel;
  logic [DW-1:0]      mode_reg, aux_reg;
  logic [N_SH*DW-1:0] nv_flat;

  shadow_ctrl_decode #(.DW(DW), .N_SH(N_SH), .ADDR_W(ADDR_W)) u_dec (
    .clk_i, .rst_ni, .wp_ni, .wr_i, .addr_i, .wdata_i,
    .sh_we_o(sh_we), .recall_o(recall), .wt_mode_o(wt_mode),
    .mode_reg_o(mode_reg), .aux_reg_o(aux_reg), .wel_o(wel)
  );

  for (genvar k = 0; k < N_SH; k++) begin : g_cell
    shadow_ctrl_cell #(.DW(DW), .INIT(NV_INIT[k*DW +: DW])) u_cell (
      .clk_i, .rst_ni,
      .we_i(sh_we[k]), .wt_i(wt_mode), .recall_i(recall), .wdata_i,
      .vol_o(vol_o[k*DW +: DW]), .nv_o(nv_flat[k*DW +: DW]),
      .commit_o(nv_commit_o[k])
    );
  end

  shadow_ctrl_rdmux #(.DW(DW), .N_SH(N_SH), .ADDR_W(ADDR_W)) u_rd (
    .clk_i, .rst_ni, .rd_i, .addr_i, .nv_i(nv_flat),
    .mode_reg_i(mode_reg), .aux_reg_i(aux_reg), .wel_i(wel), .rdata_o
  );

  a_r7_wp_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |=> (nv_commit_o == '0));
  a_r7_wp_vol_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wp_ni && !$past(!rst_ni)) |=> $stable(vol_o));
endmodule

// File: tb/sim_shadow_ctrl_bank.sv
`timescale 1ns/1ps
module sim_shadow_ctrl_bank;
  localparam logic [31:0] NV_INIT = 32'hC33C_A55A;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wp_ni = 1'b1, wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [31:0] vol_o;
  logic [3:0] nv_commit_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_vol [4];
  logic [7:0] m_nv  [4];
  logic [7:0] m_c0, m_c5;
  logic       m_wel;

  always #2.5 clk = ~clk;

  shadow_ctrl_bank u0 (
    .clk_i(clk), .rst_ni, .wp_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .rdata_o, .vol_o, .nv_commit_o
  );

  function automatic logic [31:0] pack_vol();
    return {m_vol[3], m_vol[2], m_vol[1], m_vol[0]};
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_c0;
      3'd1, 3'd2, 3'd3, 3'd4: return m_nv[a-1];
      3'd5: return m_c5;
      3'd6: return {7'b0, m_wel};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic do_write(input string tag, input logic [2:0] a, input logic [7:0] d);
    logic [3:0] exp_commit = '0;
    logic ok = (a == 3'd6) || (a != 3'd7 && m_wel && wp_ni);
    if (a == 3'd6) m_wel = d[0];
    else if (ok) begin
      if (a == 3'd0 || a == 3'd5) begin
        if (!m_c0[7]) for (int k = 0; k < 4; k++) m_vol[k] = m_nv[k];
        if (a == 3'd0) m_c0 = d; else m_c5 = d;
      end else begin
        m_vol[a-1] = d;
        if (m_c0[7]) begin
          m_nv[a-1] = d;
          exp_commit[a-1] = 1'b1;
        end
      end
    end
    @(negedge clk);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_i = 1'b0;
    check({tag, " commit"}, {28'b0, nv_commit_o}, {28'b0, exp_commit});
    check({tag, " vol"}, vol_o, pack_vol());
  endtask

  task automatic do_read(input string tag, input logic [2:0] a);
    @(negedge clk);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_i = 1'b0;
    check({tag, " rdata"}, {24'b0, rdata_o}, {24'b0, exp_read(a)});
  endtask

  task automatic power_cycle();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check("R1 vol in reset", vol_o, 32'h0);
    m_c0 = '0; m_c5 = '0; m_wel = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) m_vol[k] = m_nv[k];
    @(negedge clk);
    check("R1 recall after reset", vol_o, pack_vol());
  endtask

  initial begin
    void'($urandom(32'd20251));
    for (int k = 0; k < 4; k++) begin
      m_nv[k] = NV_INIT[k*8 +: 8];
      m_vol[k] = '0;
    end
    m_c0 = '0; m_c5 = '0; m_wel = 1'b0;
    #1;
    check("R1 vol in reset", vol_o, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 4; k++) m_vol[k] = m_nv[k];
    @(negedge clk);
    check("R1 recall at power-up", vol_o, pack_vol());
    do_read("R6 wel reset", 3'd6);
    do_read("R8 reg0 reset", 3'd0);

    do_write("R7 no wel blocks", 3'd1, 8'h11);
    do_read("R5 nv unchanged", 3'd1);
    wp_ni = 1'b0;
    do_write("R6 wel under wp", 3'd6, 8'h01);
    do_read("R6 wel read", 3'd6);
    do_write("R7 wp blocks reload", 3'd5, 8'h66);
    do_read("R7 reg5 kept", 3'd5);
    do_write("R7 wp blocks shadow", 3'd2, 8'h77);
    wp_ni = 1'b1;
    do_write("R3 vol-only", 3'd2, 8'h77);
    do_read("R5 reads nv", 3'd2);
    do_write("R4 reload via reg5", 3'd5, 8'h5E);
    do_read("R8 reg5 read", 3'd5);
    do_write("R3 vol-only", 3'd4, 8'h12);
    do_write("R4 reload via reg0 into wt", 3'd0, 8'h80);
    do_write("R2 write-through", 3'd3, 8'h99);
    do_read("R2 nv updated", 3'd3);
    do_write("R4 no reload old mode 1", 3'd0, 8'h00);
    do_write("R3 vol-only", 3'd1, 8'hE1);
    do_write("R8 addr7 ignored", 3'd7, 8'hFF);
    do_read("R8 addr7 read", 3'd7);
    power_cycle();
    do_read("R6 wel after power", 3'd6);
    do_read("R2 nv kept", 3'd3);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] a = 3'($urandom % 8);
      logic [7:0] d = 8'($urandom);
      @(negedge clk);
      wp_ni = ($urandom % 5) != 0;
      if (a == 3'd6) d[0] = ($urandom % 5) != 0;
      if (($urandom % 10) < 7) do_write("R7 random write", a, d);
      else do_read("R5 random read", a);
      if (i == 200) power_cycle();
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule